// File: doc/BRIEF.md
# Motor Lock Protection Timer

This block guards a brushless motor drive against a stalled rotor. While the motor is commanded to run and the speed-lock flag reports that the rotor is outside its lock window, an accumulator counts up once per tick. When it reaches a programmable trip count, a fault is latched and the low-side drivers are switched off. A stop command clears the fault and drains the accumulator at a faster rate, the way a timing capacitor would discharge. If the stop is too short, some count remains and the next trip comes early.

An accumulator replaces the timing capacitor of an analog design. The trip time is set by `trip_ticks`, and the drain rate is a fixed multiple of the fill rate. A strap input turns the whole protection off. The start/stop and lock inputs are asynchronous and pass through a two-flop synchroniser before use. The strap is treated as static and is used directly.

Top module: `mlp_lock_guard`

## Requirements
- R1: After reset, `fault` and `lowside_off` are 0.
- R2: With `run_cmd`=1 and `unlocked`=1 applied from an empty accumulator (with `trip_ticks`=N, a tick on every clock because TICK_DIV=1, and a two-flop synchroniser), `fault` rises on the N+2-th rising clock edge after the inputs change, and not earlier.
- R3: Once latched, `fault` stays 1 for as long as `run_cmd` stays 1, whatever `unlocked` does. The accumulator holds its value while the fault is latched.
- R4: `fault` clears on the third rising edge after `run_cmd` falls: two synchroniser edges, then one update.
- R5: While running with `unlocked`=0 (and no fault), the accumulator is cleared. A later unlocked period therefore needs the full N+2 edges to trip.
- R6: While `prot_off`=1, `fault` stays 0 and the accumulator is held at 0. Raising `prot_off` clears a latched fault on the next edge. After `prot_off` falls during run-and-unlocked, the trip comes N edges later.
- R7: During a stop, the accumulator falls by DISCH_STEP (22) per tick and saturates at 0. A stop of S clock cycles leaves r = max(0, N − 22·S). The next run-and-unlocked period then trips after (N − r) + 2 edges.
- R8: `trip_ticks` is compared live on every tick, so a small value such as 3 trips after 5 edges.
- R9: `lowside_off` always equals `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_cmd | input | 1 | 1 = run, 0 = stop (asynchronous) |
| unlocked | input | 1 | 1 = speed outside lock window (asynchronous) |
| prot_off | input | 1 | Static strap; 1 disables protection |
| trip_ticks | input | CW | Trip count in ticks |
| fault | output | 1 | Latched lock-protection fault |
| lowside_off | output | 1 | Low-side driver disable |

## Verification
The accumulator is driven from empty, from a latched fault through a short stop, and from a fault through a long stop. The trip edge count then separates a correct drain rate and zero saturation from a missing drain or a drain that never reaches zero. A run broken by a locked interval shows whether locking really clears the count rather than pausing it. A strap-release run shows whether the strap held the count at zero. A reduced trip value checks the live comparison, and an unlocked/locked toggle after a trip checks that only a stop releases the fault.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
   typedef enum logic [2:0] {
      ACC_OFF    = 3'd0,
      ACC_DRAIN  = 3'd1,
      ACC_FLUSH  = 3'd2,
      ACC_FILL   = 3'd3,
      ACC_FREEZE = 3'd4
   } acc_mode_e;
endpackage

// File: rtl/mlp_sync.sv
module mlp_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("mlp_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("mlp_sync: WIDTH must be positive");
   end

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[gi] <= '0;
               else        stage_q[gi] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[gi] <= '0;
               else        stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mlp_tick.sv
module mlp_tick #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   initial begin
      assert (TICK_DIV >= 1) else $error("mlp_tick: TICK_DIV must be at least 1");
   end

   generate
      if (TICK_DIV == 1) begin : g_every
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
         assign tick = tick_q;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] cnt_q;
         logic          tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               tick_q <= 1'b0;
            end else begin
               tick_q <= (cnt_q == LAST);
               cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end
         assign tick = tick_q;
      end
   endgenerate
endmodule

// File: rtl/mlp_mode.sv
module mlp_mode
   import mlp_pkg::*;
(
   input  logic      run_s,
   input  logic      unl_s,
   input  logic      prot_off,
   input  logic      fault_q,
   output acc_mode_e mode
);
   always_comb begin
      if (prot_off)      mode = ACC_OFF;
      else if (!run_s)   mode = ACC_DRAIN;
      else if (fault_q)  mode = ACC_FREEZE;
      else if (unl_s)    mode = ACC_FILL;
      else               mode = ACC_FLUSH;
   end
endmodule

// File: rtl/mlp_accum.sv
module mlp_accum
   import mlp_pkg::*;
#(
   parameter int CW         = 16,
   parameter int DISCH_STEP = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  acc_mode_e     mode,
   input  logic          tick,
   input  logic [CW-1:0] trip_ticks,
   output logic [CW-1:0] acc_q,
   output logic          fault_q
);
   localparam logic [CW-1:0] STEP = CW'(DISCH_STEP);

   initial begin
      assert (CW >= 2) else $error("mlp_accum: CW must be at least 2");
      assert (DISCH_STEP >= 1 && DISCH_STEP < (1 << CW))
         else $error("mlp_accum: DISCH_STEP out of range");
   end

   logic [CW:0]   inc_w;
   logic [CW-1:0] fill_v;
   logic [CW-1:0] drain_v;
   logic          reach;

   always_comb begin
      inc_w   = {1'b0, acc_q} + {{CW{1'b0}}, 1'b1};
      fill_v  = inc_w[CW] ? acc_q : inc_w[CW-1:0];
      drain_v = (acc_q >= STEP) ? (acc_q - STEP) : '0;
      reach   = (fill_v >= trip_ticks);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (mode)
            ACC_OFF: begin
               acc_q   <= '0;
               fault_q <= 1'b0;
            end
            ACC_DRAIN: begin
               fault_q <= 1'b0;
               if (tick) acc_q <= drain_v;
            end
            ACC_FLUSH: acc_q <= '0;
            ACC_FILL: begin
               if (tick) begin
                  acc_q <= fill_v;
                  if (reach) fault_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mlp_lock_guard.sv
module mlp_lock_guard
   import mlp_pkg::*;
#(
   parameter int CW          = 16,
   parameter int TICK_DIV    = 1,
   parameter int DISCH_STEP  = 22,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_cmd,
   input  logic          unlocked,
   input  logic          prot_off,
   input  logic [CW-1:0] trip_ticks,
   output logic          fault,
   output logic          lowside_off
);
   logic [1:0]    sync_o;
   logic          run_s;
   logic          unl_s;
   logic          tick;
   acc_mode_e     mode;
   logic [CW-1:0] acc_q;
   logic          fault_q;

   mlp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in({run_cmd, unlocked}), .d_out(sync_o)
   );
   assign run_s = sync_o[1];
   assign unl_s = sync_o[0];

   mlp_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   mlp_mode u_mode (
      .run_s(run_s), .unl_s(unl_s), .prot_off(prot_off),
      .fault_q(fault_q), .mode(mode)
   );

   mlp_accum #(.CW(CW), .DISCH_STEP(DISCH_STEP)) u_accum (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
      .trip_ticks(trip_ticks), .acc_q(acc_q), .fault_q(fault_q)
   );

   assign fault       = fault_q;
   assign lowside_off = fault_q;
endmodule

// File: rtl/mlp_lock_guard_chk.sv
module mlp_lock_guard_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_s,
   input logic          unl_s,
   input logic          prot_off,
   input logic          tick,
   input logic          fault_q,
   input logic          lowside_off,
   input logic [CW-1:0] acc_q,
   input logic [CW-1:0] trip_ticks
);
   // R2: a fault only appears once the count has reached the trip value
   assert_trip_reached_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> (acc_q >= trip_ticks) && $past(run_s) && $past(unl_s));

   // R3: latched fault with run held keeps fault and count
   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && run_s && !prot_off) |=> fault_q && $stable(acc_q));

   // R4: a stop clears the fault
   assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_s) |=> !fault_q);

   // R5: locked running clears the count
   assert_lock_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_s && !unl_s && !fault_q && !prot_off) |=> (acc_q == '0));

   // R6: strap forces idle state
   assert_strap_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prot_off |=> (!fault_q && acc_q == '0));

   // R7: draining never increases the count
   assert_drain_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_s && !prot_off && tick) |=> (acc_q <= $past(acc_q)));

   // R9: disable output follows fault
   always_comb begin
      assert_disable_match_R9: assert (!rst_n || lowside_off == fault_q);
   end
endmodule

bind mlp_lock_guard mlp_lock_guard_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_s(run_s), .unl_s(unl_s),
   .prot_off(prot_off), .tick(tick), .fault_q(fault_q),
   .lowside_off(lowside_off), .acc_q(acc_q), .trip_ticks(trip_ticks)
);

// File: tb/mlp_lock_guard_bench.sv
module mlp_lock_guard_bench;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_cmd = 1'b0;
   logic          unlocked = 1'b0;
   logic          prot_off = 1'b0;
   logic [CW-1:0] trip_ticks = 16'd100;
   logic          fault;
   logic          lowside_off;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #2 clk = ~clk;

   mlp_lock_guard #(.CW(CW)) u_mlp_lock_guard (
      .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .unlocked(unlocked),
      .prot_off(prot_off), .trip_ticks(trip_ticks),
      .fault(fault), .lowside_off(lowside_off)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_tests = n_tests + 1;
         n_fail  = n_fail + 1;
         $display("FAIL watchdog: run did not finish (cycles %0d, expected < 150000)", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // counts rising edges until fault is seen, capped at limit
   task automatic edges_to_fault(input int limit, output int n);
      n = limit;
      for (int i = 1; i <= limit; i++) begin
         edges(1);
         check("R9 lowside_off equals fault", lowside_off, fault);
         if (fault) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic drain_fully();
      run_cmd = 1'b0; unlocked = 1'b1; prot_off = 1'b0;
      edges(12);
   endtask

   task automatic t_reset();
      check("R1 fault after reset", fault, 0);
      check("R1 lowside_off after reset", lowside_off, 0);
   endtask

   task automatic t_fresh_trip();
      int n;
      drain_fully();
      trip_ticks = 16'd10;
      run_cmd = 1'b1; unlocked = 1'b1;
      edges_to_fault(50, n);
      check("R2 edges to trip N=10", n, 12);
      check("R9 lowside_off on trip", lowside_off, 1);
   endtask

   task automatic t_latch_hold();
      // continues from a latched fault with run held
      unlocked = 1'b0;
      edges(10);
      check("R3 fault held while locked", fault, 1);
      unlocked = 1'b1;
      edges(5);
      check("R3 fault held while unlocked", fault, 1);
   endtask

   task automatic t_stop_clear();
      run_cmd = 1'b0;
      edges(2);
      check("R4 fault still set two edges after stop", fault, 1);
      edges(1);
      check("R4 fault cleared third edge after stop", fault, 0);
      check("R9 lowside_off cleared", lowside_off, 0);
   endtask

   task automatic t_short_stop();
      int n;
      drain_fully();
      trip_ticks = 16'd100;
      run_cmd = 1'b1; unlocked = 1'b1;
      edges_to_fault(200, n);
      check("R2 edges to trip N=100", n, 102);
      run_cmd = 1'b0;
      edges(3);
      run_cmd = 1'b1;
      // residual 100-66=34, trip after 66+2
      edges_to_fault(200, n);
      check("R7 early trip after 3-cycle stop", n, 68);
   endtask

   task automatic t_long_stop();
      int n;
      // from a latched fault at count 100; 5 cycles drain 110 > 100
      run_cmd = 1'b0;
      edges(5);
      run_cmd = 1'b1;
      edges_to_fault(200, n);
      check("R7 full trip after 5-cycle stop (saturate at 0)", n, 102);
   endtask

   task automatic t_lock_flush();
      int n;
      drain_fully();
      trip_ticks = 16'd100;
      run_cmd = 1'b1; unlocked = 1'b1;
      edges(50);
      check("R5 no fault before trip", fault, 0);
      unlocked = 1'b0;
      edges(3);
      unlocked = 1'b1;
      edges_to_fault(200, n);
      check("R5 full trip after locked interval", n, 102);
   endtask

   task automatic t_strap();
      int n;
      drain_fully();
      trip_ticks = 16'd100;
      prot_off = 1'b1; run_cmd = 1'b1; unlocked = 1'b1;
      edges(150);
      check("R6 no fault with strap set", fault, 0);
      prot_off = 1'b0;
      edges_to_fault(200, n);
      check("R6 trip N edges after strap release", n, 100);
      prot_off = 1'b1;
      edges(1);
      check("R6 strap clears latched fault", fault, 0);
      check("R6 strap clears lowside_off", lowside_off, 0);
      prot_off = 1'b0;
   endtask

   task automatic t_small_trip();
      int n;
      drain_fully();
      trip_ticks = 16'd3;
      run_cmd = 1'b1; unlocked = 1'b1;
      edges_to_fault(50, n);
      check("R8 edges to trip N=3", n, 5);
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(2);
      t_reset();
      t_fresh_trip();
      t_latch_hold();
      t_stop_clear();
      t_short_stop();
      t_long_stop();
      t_lock_flush();
      t_strap();
      t_small_trip();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule